// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, every clock, the most urgent interrupt source of two separate classes. One class is fast interrupts (FIQ) and the other is ordinary interrupts (IRQ). Up to 40 sources each present three bits: a pending bit, an enable bit and a class-select bit. The class-select bit sends an enabled, pending source to the FIQ class when it is 1 and to the IRQ class when it is 0.

Urgency does not follow the source number. It comes from a ranking table of 40 slots. Each slot is a 32-bit word that names one source and carries a flag that says whether the slot is in use. The slot with the smallest index is the most urgent. The resolver walks the table once for each class. Each walk finds the first usable slot whose source qualifies for that class.

The two winners go into one 32-bit status word, and each has its own found flag. The status word is registered. It is rebuilt on every clock edge from the inputs present at that edge. Software or a sequencer outside the block can read it to learn which handler to run first.

Top module: `prio_resolver`

## Requirements
- R1: While reset is held, and on the first cycles after it, the status word is 0x003F003F.
- R2: A slot counts only if its bit 31 is 1 and its source ID in bits 5:0 is below 40. An unused slot has no effect on the result. A slot whose ID is 40 to 63 also has no effect.
- R3: Among the usable slots whose source qualifies for a class, the slot with the lowest index gives that class's winner.
- R4: A source qualifies for the FIQ class only when its pending, enable and class-select bits are all 1.
- R5: A source qualifies for the IRQ class only when its pending and enable bits are 1 and its class-select bit is 0.
- R6: An IRQ winner is reported with status bit 31 set and its source ID in bits 21:16. Bits 30:22 are always 0.
- R7: A FIQ winner is reported with status bit 15 set and its source ID in bits 5:0. Bits 14:6 are always 0.
- R8: When a class has no winner, its flag bit is 0 and its ID field reads 0x3F.
- R9: The FIQ and IRQ results are independent of each other. Adding sources of one class never changes the other class's field.
- R10: When the same source ID sits in several usable slots, the lowest of those slots sets that source's rank.
- R11: The status word changes only at a clock edge. It reflects the inputs present at the previous rising edge.
- R12: Bits 30:6 of a slot word have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 40 | Pending bit per source |
| enab_i | input | 40 | Enable bit per source |
| fiq_sel_i | input | 40 | Class select per source, 1 = FIQ, 0 = IRQ |
| slot_word_i | input | 1280 | 40 ranking slots of 32 bits, slot k in bits 32k+31:32k |
| status_o | output | 32 | Registered status word with the IRQ and FIQ winners |

## Verification
The bench aims at the slots the resolver must skip. These are unused slots and slots with IDs 40 to 63 (a design that indexed past the source range would report a phantom winner). It also tests slot words that carry junk in their middle bits, which a design that decoded the full word would misread. Tables are ranked in the reverse of source order and contain duplicate IDs, so a design that ranked by source number or by the highest slot would name the wrong winner. Mixed FIQ and IRQ loads show whether one class leaks into the other. The empty-class pattern 0x3F is checked, along with the one-cycle latency, which a transparent or doubly registered output would break.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

  localparam int WORD_W   = 32;
  localparam int ID_W     = 6;
  localparam int SLOT_VLD = 31;

  localparam int IRQ_FLAG = 31;
  localparam int IRQ_LSB  = 16;
  localparam int FIQ_FLAG = 15;
  localparam int FIQ_LSB  = 0;

  localparam logic [ID_W-1:0] NO_ID = '1;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } winner_t;

  function automatic logic [WORD_W-1:0] pack_status(winner_t irq_w, winner_t fiq_w);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IRQ_FLAG]               = irq_w.found;
    w[IRQ_LSB +: ID_W]        = irq_w.found ? irq_w.id : NO_ID;
    w[FIQ_FLAG]               = fiq_w.found;
    w[FIQ_LSB +: ID_W]        = fiq_w.found ? fiq_w.id : NO_ID;
    return w;
  endfunction

endpackage

// File: rtl/prio_qualify.sv
module prio_qualify #(
  parameter int NSRC = 40
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] enab,
  input  logic [NSRC-1:0] fiq_sel,
  output logic [NSRC-1:0] fiq_req,
  output logic [NSRC-1:0] irq_req
);

  logic [NSRC-1:0] live;

  always_comb begin
    live    = pend & enab;
    fiq_req = live & fiq_sel;
    irq_req = live & ~fiq_sel;
  end

endmodule

// File: rtl/prio_slot_decode.sv
module prio_slot_decode
  import prio_res_pkg::*;
#(
  parameter int NSRC = 40
) (
  input  logic [NSRC*WORD_W-1:0] slot_word,
  input  logic [NSRC-1:0]        fiq_req,
  input  logic [NSRC-1:0]        irq_req,
  output logic [NSRC-1:0]        fiq_hit,
  output logic [NSRC-1:0]        irq_hit,
  output logic [NSRC*ID_W-1:0]   slot_id
);

  localparam int CMP_W = ID_W + 1;
  localparam logic [CMP_W-1:0] SRC_LIM = CMP_W'(NSRC);

  logic [NSRC*(WORD_W-ID_W-1)-1:0] pad_unused;

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    logic [ID_W-1:0] id;
    logic            vld;
    logic            usable;
    logic            fiq_sel_req;
    logic            irq_sel_req;

    assign id  = slot_word[s*WORD_W +: ID_W];
    assign vld = slot_word[s*WORD_W + SLOT_VLD];
    assign pad_unused[s*(WORD_W-ID_W-1) +: (WORD_W-ID_W-1)] =
      slot_word[s*WORD_W + ID_W +: (WORD_W-ID_W-1)];

    always_comb begin
      usable      = vld && ({1'b0, id} < SRC_LIM);
      fiq_sel_req = 1'b0;
      irq_sel_req = 1'b0;
      for (int j = 0; j < NSRC; j++) begin
        if (id == ID_W'(j)) begin
          fiq_sel_req = fiq_req[j];
          irq_sel_req = irq_req[j];
        end
      end
    end

    assign fiq_hit[s]              = usable && fiq_sel_req;
    assign irq_hit[s]              = usable && irq_sel_req;
    assign slot_id[s*ID_W +: ID_W] = id;
  end

  logic pad_bits_unused;
  assign pad_bits_unused = ^pad_unused;

endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import prio_res_pkg::*;
#(
  parameter int NSLOT = 40
) (
  input  logic [NSLOT-1:0]      hit,
  input  logic [NSLOT*ID_W-1:0] ids,
  output winner_t               win
);

  always_comb begin
    win.found = 1'b0;
    win.id    = NO_ID;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (hit[s]) begin
        win.found = 1'b1;
        win.id    = ids[s*ID_W +: ID_W];
      end
    end
  end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int NSRC = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC-1:0]        enab_i,
  input  logic [NSRC-1:0]        fiq_sel_i,
  input  logic [NSRC*WORD_W-1:0] slot_word_i,
  output logic [WORD_W-1:0]      status_o
);

  localparam logic [WORD_W-1:0] IDLE_WORD = pack_status('{found: 1'b0, id: NO_ID},
                                                        '{found: 1'b0, id: NO_ID});

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NSRC-1:0]      fiq_req;
  logic [NSRC-1:0]      irq_req;
  logic [NSRC-1:0]      fiq_hit;
  logic [NSRC-1:0]      irq_hit;
  logic [NSRC*ID_W-1:0] slot_id;
  winner_t              fiq_win;
  winner_t              irq_win;

  prio_qualify #(.NSRC(NSRC)) u_qual (
    .pend    (pend_i),
    .enab    (enab_i),
    .fiq_sel (fiq_sel_i),
    .fiq_req (fiq_req),
    .irq_req (irq_req)
  );

  prio_slot_decode #(.NSRC(NSRC)) u_slots (
    .slot_word (slot_word_i),
    .fiq_req   (fiq_req),
    .irq_req   (irq_req),
    .fiq_hit   (fiq_hit),
    .irq_hit   (irq_hit),
    .slot_id   (slot_id)
  );

  prio_pick #(.NSLOT(NSRC)) u_pick_fiq (
    .hit (fiq_hit),
    .ids (slot_id),
    .win (fiq_win)
  );

  prio_pick #(.NSLOT(NSRC)) u_pick_irq (
    .hit (irq_hit),
    .ids (slot_id),
    .win (irq_win)
  );

  logic [WORD_W-1:0] status_d;
  logic              status_en;

  always_comb begin
    status_en = 1'b1;
    status_d  = pack_status(irq_win, fiq_win);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_o <= IDLE_WORD;
    end else if (status_en) begin
      status_o <= status_d;
    end
  end

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NSRC = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] pend_i,
  input logic [NSRC-1:0] enab_i,
  input logic [NSRC-1:0] fiq_sel_i,
  input logic [31:0]     status_o
);

  logic any_fiq;
  logic any_irq;
  assign any_fiq = |(pend_i & enab_i & fiq_sel_i);
  assign any_irq = |(pend_i & enab_i & ~fiq_sel_i);

  // R8
  irq_empty_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[31] |-> status_o[21:16] == 6'h3F);

  // R8
  fiq_empty_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[15] |-> status_o[5:0] == 6'h3F);

  // R6
  irq_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[30:22] == 9'd0);

  // R7
  fiq_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[14:6] == 9'd0);

  // R4
  fiq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fiq |=> !status_o[15]);

  // R5
  irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_irq |=> !status_o[31]);

  // R6
  irq_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31] |-> {2'b00, status_o[21:16]} < NSRC);

  // R7
  fiq_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15] |-> {2'b00, status_o[5:0]} < NSRC);

endmodule

bind prio_resolver prio_resolver_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_i    (pend_i),
  .enab_i    (enab_i),
  .fiq_sel_i (fiq_sel_i),
  .status_o  (status_o)
);

// File: tb/prio_resolver_tb.sv
`timescale 1ns/1ps
module prio_resolver_tb;

  localparam int N = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    pend, enab, fsel;
  logic [N*32-1:0] slots;
  logic [31:0]     status;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q;

  always #2.5 clk = ~clk;

  prio_resolver #(.NSRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab),
    .fiq_sel_i(fsel), .slot_word_i(slots), .status_o(status)
  );

  function automatic logic [31:0] model();
    int irq = -1;
    int fiq = -1;
    logic [31:0] r;
    for (int s = 0; s < N; s++) begin
      logic [31:0] w;
      int id;
      w  = slots[s*32 +: 32];
      id = int'(w[5:0]);
      if (w[31] && id < N && pend[id] && enab[id]) begin
        if (fsel[id] && fiq < 0) fiq = id;
        if (!fsel[id] && irq < 0) irq = id;
      end
    end
    r = 32'h003F003F;
    if (irq >= 0) r = (r & 32'h0000FFFF) | 32'h80000000 | (irq << 16);
    if (fiq >= 0) r = (r & 32'hFFFF0000) | 32'h00008000 | fiq;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: status=%h expected=%h", tag, got, want);
    end
  endtask

  task automatic apply(string tag);
    @(posedge clk);
    exp_q = model();
    @(negedge clk);
    check(tag, status, exp_q);
  endtask

  task automatic set_slot(int s, bit vld, int id, logic [24:0] junk = '0);
    slots[s*32 +: 32] = {vld, junk, 6'(id)};
  endtask

  task automatic clear_all();
    pend = '0; enab = '0; fsel = '0; slots = '0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: status=%h expected=done", status);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    check("R1 in reset", status, 32'h003F003F);
    rst_n = 1'b1;
    repeat (3) apply("R1 after reset");
    check("R1 idle", status, 32'h003F003F);

    // identity ranking, one IRQ source
    for (int s = 0; s < N; s++) set_slot(s, 1'b1, s);
    pend[9] = 1; enab[9] = 1;
    apply("R6 single irq");
    check("R6 irq field", status, 32'h8009003F);

    // R11: inputs change at negedge, output holds until the edge
    pend[3] = 1; enab[3] = 1; fsel[3] = 1;
    #1 check("R11 hold before edge", status, 32'h8009003F);
    apply("R11 after edge");
    check("R7 fiq field", status, 32'h80098003);

    // R4 enable gate
    enab[3] = 0;
    apply("R4 disabled fiq");
    enab[3] = 1; pend[3] = 0;
    apply("R4 not pending fiq");

    // R5 class select
    fsel[9] = 1;
    apply("R5 irq moved to fiq");
    check("R5 value", status, 32'h003F8009);

    // R3 reversed ranking
    clear_all();
    for (int s = 0; s < N; s++) set_slot(s, 1'b1, N - 1 - s);
    pend[5] = 1; enab[5] = 1; pend[30] = 1; enab[30] = 1;
    apply("R3 reversed");
    check("R3 reversed value", status, 32'h801E003F);

    // R2 unused slot skipped
    set_slot(9, 1'b0, 30);
    apply("R2 slot invalid");
    check("R2 invalid value", status, 32'h8005003F);

    // R2 out-of-range IDs ahead of valid ones
    clear_all();
    set_slot(0, 1'b1, 40); set_slot(1, 1'b1, 63); set_slot(2, 1'b1, 45);
    set_slot(3, 1'b1, 12);
    pend = '1; enab = '1;
    apply("R2 out of range");
    check("R2 range value", status, 32'h800C003F);

    // R12 junk in slot middle bits
    clear_all();
    set_slot(0, 1'b1, 17, 25'h1ABCDEF);
    set_slot(1, 1'b1, 2, 25'h1FFFFFF);
    pend[2] = 1; enab[2] = 1; fsel[2] = 1; pend[17] = 1; enab[17] = 1;
    apply("R12 junk bits");
    check("R12 value", status, 32'h80118002);

    // R10 duplicates: slot 0 and 2 name 5, slot 1 names 7
    clear_all();
    set_slot(0, 1'b1, 5); set_slot(1, 1'b1, 7); set_slot(2, 1'b1, 5);
    pend[5] = 1; enab[5] = 1; pend[7] = 1; enab[7] = 1;
    apply("R10 duplicate");
    check("R10 value", status, 32'h8005003F);
    set_slot(0, 1'b0, 5);
    apply("R10 lower copy removed");
    check("R10 value2", status, 32'h8007003F);

    // R9 independence: add many fiq sources, irq field unchanged
    clear_all();
    for (int s = 0; s < N; s++) set_slot(s, 1'b1, (s * 7) % N);
    pend[21] = 1; enab[21] = 1;
    apply("R9 irq only");
    check("R9 base", status[31:16], 16'h8015);
    pend[N-1:30] = '1; enab[N-1:30] = '1; fsel[N-1:30] = '1;
    apply("R9 fiq added");
    check("R9 irq unchanged", status[31:16], 16'h8015);
    pend[21] = 0;
    apply("R9 irq removed");
    check("R8 irq empty", status[31:16], 16'h003F);

    // R3 random patterns
    for (int k = 0; k < 400; k++) begin
      pend = {$urandom, $urandom};
      enab = {$urandom, $urandom};
      fsel = {$urandom, $urandom};
      for (int s = 0; s < N; s++)
        slots[s*32 +: 32] = $urandom;
      apply("R3 random");
    end

    clear_all();
    apply("R8 empty");
    check("R8 empty value", status, 32'h003F003F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule